// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

The block moves one 8-bit byte at a time over a clocked serial link and takes one byte back in the same frame. A parallel side hands it the outgoing byte and a start request. When the byte is finished it returns the incoming byte with a one-cycle completion pulse. The serial side has a clock, a data output, a data input and an active-low chip select.

As **master**, the block makes the serial clock from the system clock at one of seven selectable rates. It drives that clock out only while a frame is in progress, and it drives chip select itself. As **slave**, it follows a clock and chip select supplied from outside. It brings those signals into its own clock domain through two-flop synchronizers and finds the clock edges by comparing successive samples.

Three settings shape the frame:
- **Polarity** sets the level of the clock when idle.
- **Phase** picks whether data is sampled on the leading edge or the trailing edge.
- **Bit order** picks whether bit 0 or bit 7 goes first.

A simplified-mode input makes the block ignore the phase setting and always use phase-0 timing. Polarity still applies in that mode. All configuration inputs are expected to stay fixed while a frame is in progress.

Top module: `serial_shift_engine`

## Requirements
- R1: After reset is released, `busy`, `done` and `rx_byte` read 0, `cs_n_o` reads 1, and `sclk_o` equals `cfg_cpol`.
- R2: In master mode the serial clock half-period is 2^k system cycles for rate code k in 1..7, so the full period is system clock divided by 4, 8, …, 256. Code 0 behaves like code 1.
- R3: In master mode `sclk_oe` is 1, and `sclk_o` stays at the idle level `cfg_cpol` until a frame starts. A frame makes exactly 16 clock transitions and then leaves the clock at `cfg_cpol`. The leading edge is the transition away from the idle level.
- R4: In master mode, a `start` accepted while idle makes `busy` 1 and `cs_n_o` 0 on the next cycle. Both stay that way for the whole byte. `cs_n_o` returns to 1 in the cycle in which `done` pulses.
- R5: With effective phase 0, the first data bit is on `sdo` from the moment chip select goes active. Data is sampled on each leading edge and changes on each trailing edge.
- R6: With effective phase 1, data changes on each leading edge and is sampled on each trailing edge.
- R7: While `cfg_simple` is 1, `cfg_cpha` has no effect: timing is that of phase 0, and `cfg_cpol` still sets the idle level.
- R8: With `cfg_msb_first` = 0, bits go out and come in in the order bit 0 to bit 7. With 1, the order is bit 7 to bit 0.
- R9: `done` is a single-cycle pulse. `rx_byte` takes the received byte in that same cycle and holds it until the next pulse.
- R10: In slave mode, a falling `cs_n_i` loads `tx_byte` and starts a frame clocked by `sclk_i`. `done` pulses after the 16th `sclk_i` transition. `busy` follows the synchronized chip select.
- R11: In slave mode, if `cs_n_i` rises before 16 transitions, the frame is abandoned: no `done` pulse, and `busy` goes to 0.
- R12: A `start` pulse during a master frame is ignored. The frame in progress keeps its byte and its 16 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_simple | input | 1 | Simplified mode; forces phase 0 |
| cfg_msb_first | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| cfg_rate | input | 3 | Master clock rate code |
| tx_byte | input | 8 | Byte to send |
| start | input | 1 | Master frame request (one cycle) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse, received byte valid |
| rx_byte | output | 8 | Last received byte |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock in (slave) |
| cs_n_o | output | 1 | Chip select out, active low (master) |
| cs_n_i | input | 1 | Chip select in, active low (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume that the configuration inputs do not change while `busy` is high. The bench sets every field before each frame and leaves it alone until the frame has ended. In slave mode, correct sampling depends on each `sclk_i` half-period being much longer than the three-cycle synchronizer delay, with `sdi` changing only on change edges. The bench's slave driver therefore holds every level for eight system cycles and moves `sdi` only at the edge where the data is meant to change.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int unsigned SSE_DATA_W = 8;
  localparam int unsigned SSE_RATE_W = 3;

  typedef struct packed {
    logic                  master;
    logic                  cpol;
    logic                  cpha_eff;
    logic                  msb_first;
    logic [SSE_RATE_W-1:0] rate;
  } sse_cfg_t;
endpackage

// File: rtl/sse_rate_div.sv
module sse_rate_div #(
  parameter int unsigned RATE_W = sse_pkg::SSE_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned CNT_W = (2 ** RATE_W) - 1;

  logic [RATE_W-1:0] eff_code;
  logic [CNT_W:0]    half;
  logic [CNT_W-1:0]  half_m1;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    eff_code = (code == '0) ? RATE_W'(1) : code;
    half     = {{CNT_W{1'b0}}, 1'b1} << eff_code;
    half_m1  = half[CNT_W-1:0] - 1'b1;
    tick     = en && (cnt_q == half_m1);
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sse_sync.sv
module sse_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]      = s2;
    assign q_prev[i] = s3;
  end
endmodule

// File: rtl/sse_xfer_ctrl.sv
module sse_xfer_ctrl
  import sse_pkg::*;
#(
  parameter int unsigned DATA_W = SSE_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sse_cfg_t          cfg,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              start,
  input  logic              tick,
  input  logic              s_edge,
  input  logic              s_cs_fall,
  input  logic              s_cs_high,
  input  logic              din,
  output logic              active,
  output logic              sclk_q,
  output logic              dout,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned ECW = $clog2(2 * DATA_W + 1);
  localparam logic [ECW-1:0] EDGES = ECW'(2 * DATA_W);
  localparam logic [ECW-1:0] LAST  = ECW'(2 * DATA_W - 1);

  logic [ECW-1:0]    ecnt_q, ecnt_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d, rxb_d;
  logic              act_d, fin_q, fin_d, sclk_d, done_d;
  logic              lead, smp, shf, edge_ev, fin_ev;

  always_comb begin
    lead    = ~ecnt_q[0];
    smp     = lead ^ cfg.cpha_eff;
    shf     = cfg.cpha_eff ? (lead && ecnt_q != '0) : (!lead && ecnt_q != LAST);
    edge_ev = (cfg.master ? tick : s_edge) && (ecnt_q < EDGES);
    fin_ev  = !fin_q && (ecnt_q == EDGES) && (cfg.master ? tick : 1'b1);

    act_d  = active;
    fin_d  = fin_q;
    ecnt_d = ecnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    rxb_d  = rx_byte;

    if (!active) begin
      sclk_d = cfg.cpol;
      ecnt_d = '0;
      fin_d  = 1'b0;
      if (cfg.master ? start : s_cs_fall) begin
        act_d = 1'b1;
        tx_d  = tx_byte;
      end
    end else if (!cfg.master && s_cs_high) begin
      act_d = 1'b0;
    end else begin
      if (edge_ev) begin
        ecnt_d = ecnt_q + 1'b1;
        if (cfg.master) sclk_d = ~sclk_q;
        if (smp) rx_d = cfg.msb_first ? {rx_q[DATA_W-2:0], din} : {din, rx_q[DATA_W-1:1]};
        if (shf) tx_d = cfg.msb_first ? {tx_q[DATA_W-2:0], 1'b0} : {1'b0, tx_q[DATA_W-1:1]};
      end
      if (fin_ev) begin
        done_d = 1'b1;
        rxb_d  = rx_q;
        fin_d  = 1'b1;
        if (cfg.master) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      fin_q   <= 1'b0;
      ecnt_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      active  <= act_d;
      fin_q   <= fin_d;
      ecnt_q  <= ecnt_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      sclk_q  <= sclk_d;
      done    <= done_d;
      rx_byte <= rxb_d;
    end
  end

  assign dout = cfg.msb_first ? tx_q[DATA_W-1] : tx_q[0];
endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
  import sse_pkg::*;
#(
  parameter int unsigned DATA_W = SSE_DATA_W,
  parameter int unsigned RATE_W = SSE_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_simple,
  input  logic              cfg_msb_first,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              cs_n_o,
  input  logic              cs_n_i,
  output logic              sdo,
  input  logic              sdi
);
  localparam int unsigned SYNC_W = 3;

  logic              rst_m, rst_n_s;
  logic [SYNC_W-1:0] sy_q, sy_prev;
  logic              tick, active, sclk_q, din;
  sse_cfg_t          cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_n_s <= rst_m;
    end
  end

  always_comb begin
    cfg.master    = cfg_master;
    cfg.cpol      = cfg_cpol;
    cfg.cpha_eff  = cfg_cpha & ~cfg_simple;
    cfg.msb_first = cfg_msb_first;
    cfg.rate      = cfg_rate;
  end

  // bit 0: serial clock, bit 1: chip select, bit 2: data in
  sse_sync #(.W(SYNC_W), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({sdi, cs_n_i, sclk_i}),
    .q(sy_q), .q_prev(sy_prev)
  );

  sse_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .en(active & cfg_master),
    .code(cfg_rate), .tick(tick)
  );

  assign din = cfg_master ? sdi : sy_q[2];

  sse_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .tx_byte(tx_byte), .start(start),
    .tick(tick), .s_edge(sy_q[0] ^ sy_prev[0]),
    .s_cs_fall(!sy_q[1] && sy_prev[1]), .s_cs_high(sy_q[1]),
    .din(din), .active(active), .sclk_q(sclk_q), .dout(sdo),
    .done(done), .rx_byte(rx_byte)
  );

  assign busy    = active;
  assign sclk_oe = cfg_master;
  assign sclk_o  = (cfg_master && active) ? sclk_q : cfg_cpol;
  assign cs_n_o  = cfg_master ? ~active : 1'b1;
endmodule

// File: rtl/sse_checker.sv
module sse_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master,
  input logic              cfg_cpol,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              sclk_q,
  input logic [DATA_W-1:0] rx_byte
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_byte));                                  // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && start && !busy) |=> (busy && !cs_n_o));        // R4
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_master) |-> (!busy && cs_n_o));                  // R4
  AST_SCLK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $rose(busy)) |-> (sclk_q == cfg_cpol));        // R3
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $fell(busy)) |-> (sclk_q == cfg_cpol));        // R3
endmodule

bind serial_shift_engine sse_checker #(.DATA_W(DATA_W)) u_sse_chk (
  .clk(clk), .rst_n(rst_n_s), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .start(start), .busy(busy), .done(done), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .sclk_q(sclk_q), .rx_byte(rx_byte)
);

// File: tb/serial_shift_engine_tb_top.sv
module serial_shift_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_simple = 1'b0;
  logic cfg_msb_first = 1'b0;
  logic [2:0] cfg_rate = 3'd1;
  logic [7:0] tx_byte = 8'h00;
  logic start = 1'b0, sclk_i = 1'b0, cs_n_i = 1'b1, sdi = 1'b0;
  logic busy, done, sclk_o, sclk_oe, cs_n_o, sdo;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_simple(cfg_simple), .cfg_msb_first(cfg_msb_first),
    .cfg_rate(cfg_rate), .tx_byte(tx_byte), .start(start), .busy(busy),
    .done(done), .rx_byte(rx_byte), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sclk_i(sclk_i), .cs_n_o(cs_n_o), .cs_n_i(cs_n_i), .sdo(sdo), .sdi(sdi)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int idx(input bit msb, input int k);
    return msb ? 7 - k : k;
  endfunction

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reset state (R1)
  task automatic t_reset();
    cfg_master = 1'b1; cfg_cpol = 1'b1;
    rst_n = 1'b0; wcyc(5); rst_n = 1'b1; wcyc(4);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(cs_n_o == 1'b1, "R1 cs_n_o", cs_n_o, 1);
    chk(sclk_o == 1'b1, "R1 sclk_o idle", sclk_o, 1);
    chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
  endtask

  // Master frame: phase (R5, R6, R7), order (R8), rate (R2), framing (R3, R4), R9, R12
  task automatic t_master(input bit pol, input bit pha, input bit simp, input bit msb,
                          input logic [2:0] rate, input logic [7:0] txb, input logic [7:0] pat);
    int edges = 0, samples = 0, e1 = 0, e2 = 0, dc0, half;
    bit poked = 0, ph, seen_done = 0;
    logic [7:0] got = 8'h00;
    logic prev;
    ph = pha & ~simp;
    half = 1 << ((rate == 3'd0) ? 1 : rate);
    cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_simple = simp;
    cfg_msb_first = msb; cfg_rate = rate; tx_byte = txb;
    sdi = pat[idx(msb, 0)];
    wcyc(2);
    chk(sclk_o == pol && cs_n_o == 1'b1 && sclk_oe == 1'b1, "R3 idle before start",
        {sclk_o, cs_n_o, sclk_oe}, {pol, 2'b11});
    dc0 = done_cnt;
    prev = sclk_o;
    start = 1'b1;
    for (int c = 0; c < 8000; c++) begin
      @(negedge clk);
      if (start) start = 1'b0;
      if (c == 0) chk(busy == 1'b1 && cs_n_o == 1'b0 && sclk_o == pol,
                      "R4 frame opens", {busy, cs_n_o, sclk_o}, {2'b10, pol});
      if (sclk_o !== prev) begin
        edges++; prev = sclk_o;
        if (edges == 1) e1 = c;
        if (edges == 2) e2 = c;
        if (((edges % 2) == 1) ^ ph) begin
          if (samples < 8) got[idx(msb, samples)] = sdo;
          samples++;
          if (samples < 8) sdi = pat[idx(msb, samples)];
        end
      end
      if (edges == 5 && !poked) begin poked = 1; start = 1'b1; tx_byte = ~txb; end
      if (edges < 16 && busy) chk(cs_n_o == 1'b0, "R4 cs held", cs_n_o, 0);
      if (!busy) begin seen_done = done; break; end
    end
    chk(seen_done, "R9 done with end of frame", seen_done, 1);
    chk(cs_n_o == 1'b1 && sclk_o == pol, "R4 release / R3 idle after", {cs_n_o, sclk_o}, {1'b1, pol});
    chk(edges == 16, "R3 edge count / R12", edges, 16);
    chk(e2 - e1 == half, "R2 half period", e2 - e1, half);
    chk(got == txb, "R5/R6/R7/R8 transmitted bits / R12", got, txb);
    chk(rx_byte == pat, "R5/R6/R7/R8 received byte", rx_byte, pat);
    @(negedge clk);
    chk(done == 1'b0 && done_cnt - dc0 == 1, "R9 single pulse", done_cnt - dc0, 1);
    chk(busy == 1'b0, "R12 no restart", busy, 0);
    tx_byte = txb;
  endtask

  // Slave frame (R10, R11) with phase/order variants
  task automatic t_slave(input bit pol, input bit pha, input bit simp, input bit msb,
                         input logic [7:0] txb, input logic [7:0] pat, input int nbits);
    int dc0;
    bit ph;
    logic [7:0] got = 8'h00;
    ph = pha & ~simp;
    cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_simple = simp;
    cfg_msb_first = msb; tx_byte = txb; sclk_i = pol; cs_n_i = 1'b1;
    wcyc(6);
    chk(cs_n_o == 1'b1 && sclk_oe == 1'b0 && busy == 1'b0, "R10 slave idle",
        {cs_n_o, sclk_oe, busy}, 3'b100);
    dc0 = done_cnt;
    cs_n_i = 1'b0;
    wcyc(SH);
    chk(busy == 1'b1, "R10 busy follows cs", busy, 1);
    for (int k = 0; k < nbits; k++) begin
      if (!ph) begin
        sdi = pat[idx(msb, k)]; wcyc(SH);
        got[idx(msb, k)] = sdo;
        sclk_i = ~pol; wcyc(SH);
        sclk_i = pol;
      end else begin
        sclk_i = ~pol; sdi = pat[idx(msb, k)]; wcyc(SH);
        got[idx(msb, k)] = sdo;
        sclk_i = pol; wcyc(SH);
      end
    end
    wcyc(SH);
    if (nbits == 8) begin
      chk(done_cnt - dc0 == 1, "R10 done after 16 edges", done_cnt - dc0, 1);
      chk(got == txb, "R10/R8 slave transmitted bits", got, txb);
      chk(rx_byte == pat, "R10/R8 slave received byte", rx_byte, pat);
      chk(busy == 1'b1, "R10 busy until cs rises", busy, 1);
    end
    cs_n_i = 1'b1;
    wcyc(6);
    chk(busy == 1'b0, "R10/R11 busy clears on cs rise", busy, 0);
    if (nbits < 8)
      chk(done_cnt == dc0, "R11 aborted frame gives no done", done_cnt - dc0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();                                                // R1
    t_master(1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'hA5, 8'h3C);     // R5 R8 lsb
    t_master(1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 8'h96, 8'hC1);     // R6 R8 msb
    t_master(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h1E, 8'h7B);     // R7 R2 code 0
    t_master(1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 8'h58, 8'hE2);     // R2 slowest
    t_master(1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 8'hC3, 8'h0F);     // R7 pol kept
    t_slave(1'b0, 1'b0, 1'b0, 1'b1, 8'h6D, 8'hB4, 8);         // R10
    t_slave(1'b1, 1'b1, 1'b0, 1'b0, 8'h2B, 8'h91, 8);         // R10 phase 1
    t_slave(1'b0, 1'b1, 1'b1, 1'b0, 8'hF0, 8'h55, 8);         // R7 slave
    t_slave(1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h42, 4);         // R11 abort
    t_slave(1'b1, 1'b0, 1'b0, 1'b1, 8'h37, 8'hD8, 8);         // R10 recovery
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule